// File: doc/BRIEF.md
# Accumulator Machine Fetch-Execute Sequencer

This block is the control unit and datapath of a small accumulator machine. Each instruction is carried out as a series of register transfers through five internal registers: the instruction pointer, the address latch that drives memory, the memory word buffer, the instruction holding register and the accumulator. One single-port memory, external to the block and with one cycle of read latency, holds both the program and its data. The block presents an address from its address latch, writes from its word buffer, and loads that buffer from the read data one cycle after each read.

An instruction word is 16 bits wide. The top 4 bits select the operation and the low 12 bits give an address. Every instruction ends with a check of the interrupt request line. If a request is pending and interrupts are unmasked, the sequencer stores the return address in memory word 0x000, continues at 0x001 and masks further requests until a return-from-interrupt instruction restores the saved address. Undefined operation codes stop the machine, as the explicit halt does.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, the instruction pointer reads RESET_PC (0x010), the accumulator reads 0, the machine is neither halted nor in service, and no memory write is issued.
- R2: The first fetch cycle copies the instruction pointer into the memory address. In the second fetch cycle that address is still on memAddr and the instruction pointer then rises by exactly 1, so it names the following instruction before execute begins.
- R3: The word read at the fetch address goes through the word buffer into the instruction register. Bits [15:12] are decoded as the operation: 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 jump, 6 jump-if-zero, 7 return-from-interrupt. Bits [11:0] form the address field.
- R4: Load, add and subtract place the address field on memAddr and then read that word. Load copies it into the accumulator. Add and subtract combine it with the accumulator modulo 2^16.
- R5: Store issues exactly one memory write of the accumulator value at the address field.
- R6: Jump always sets the instruction pointer to the address field. Jump-if-zero does so only when the accumulator is 0 and otherwise falls through to the next instruction.
- R7: Halt and the undefined codes 8 to 15 stop the sequencer for good. The instruction pointer and accumulator then hold still, and no memory write is issued.
- R8: After each completed instruction, a high irqReq with interrupts unmasked causes one write of the zero-extended instruction pointer to address 0x000. The instruction pointer then becomes 0x001 and inService rises.
- R9: While inService is high, irqReq has no effect. No further save write takes place and execution continues in the service routine.
- R10: Return-from-interrupt reads word 0x000, reloads the instruction pointer from its low 12 bits and clears inService.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 1 | Level-sensitive interrupt request |
| memRdData | input | 16 | Memory read word, valid one cycle after the address |
| memAddr | output | 12 | Memory address, taken from the address latch |
| memWrEn | output | 1 | Memory write strobe |
| memWrData | output | 16 | Memory write word, taken from the word buffer |
| accOut | output | 16 | Accumulator value |
| pcOut | output | 12 | Instruction pointer value |
| halted | output | 1 | Sequencer has stopped |
| inService | output | 1 | Interrupt mask, high inside a service routine |

## Verification
On every cycle, the assertions check the fetch address and the pointer increment, the frozen state after a halt, and the register side of interrupt entry: the save write to 0x000 of the old pointer, the jump to the vector, and that no second entry happens while masked. The bench's programs are the only evidence for the arithmetic results, the taken and not-taken jumps, the undefined-code halt, and the return from interrupt resuming at the saved address. For these programs it compares every memory write the design makes, in order, against a list worked out by hand from the instruction encodings.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_HALT  = 4'h0;
  localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
  localparam logic [OP_W-1:0] OP_STORE = 4'h2;
  localparam logic [OP_W-1:0] OP_ADD   = 4'h3;
  localparam logic [OP_W-1:0] OP_SUB   = 4'h4;
  localparam logic [OP_W-1:0] OP_JMP   = 4'h5;
  localparam logic [OP_W-1:0] OP_JZ    = 4'h6;
  localparam logic [OP_W-1:0] OP_RETI  = 4'h7;

  typedef enum logic [1:0] {
    MAR_FROM_PC,
    MAR_FROM_CIR,
    MAR_FROM_SAVE
  } marSel_e;

  typedef enum logic [1:0] {
    MBR_FROM_MEM,
    MBR_FROM_ACC,
    MBR_FROM_PC
  } mbrSel_e;

  typedef enum logic [1:0] {
    ACC_PASS,
    ACC_ADD,
    ACC_SUB
  } accOp_e;

  typedef struct packed {
    logic    marLoad;
    marSel_e marSel;
    logic    mbrLoad;
    mbrSel_e mbrSel;
    logic    cirLoad;
    logic    pcInc;
    logic    pcLoadAddr;
    logic    pcLoadMbr;
    logic    pcLoadVec;
    logic    accLoad;
    accOp_e  accOp;
    logic    memWrite;
  } ctrlStrobes_t;

  typedef enum logic [3:0] {
    ST_FETCH_ADDR,
    ST_FETCH_READ,
    ST_FETCH_MBR,
    ST_DECODE,
    ST_EXEC_ADDR,
    ST_EXEC_MEM,
    ST_EXEC_MBR,
    ST_EXEC_DO,
    ST_INT_CHECK,
    ST_INT_SAVE,
    ST_INT_WRITE,
    ST_HALTED
  } seqState_e;

endpackage

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int               ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] RESET_PC    = 12'h010,
  parameter logic [ADDR_W-1:0] SAVE_ADDR   = 12'h000,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 12'h001
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [OP_W+ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [OP_W+ADDR_W-1:0] memWrData,
  output logic [OP_W-1:0]        opcode,
  output logic                   accZero,
  output logic [OP_W+ADDR_W-1:0] accOut,
  output logic [ADDR_W-1:0]      pcOut
);

  localparam int DATA_W = OP_W + ADDR_W;

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] marQ;
  logic [DATA_W-1:0] mbrQ;
  logic [DATA_W-1:0] cirQ;
  logic [DATA_W-1:0] accQ;

  logic [ADDR_W-1:0] addrField;
  logic [ADDR_W-1:0] marNext;
  logic [DATA_W-1:0] mbrNext;
  logic [DATA_W-1:0] aluResult;

  assign addrField = cirQ[ADDR_W-1:0];

  always_comb begin
    case (strb.marSel)
      MAR_FROM_CIR:  marNext = addrField;
      MAR_FROM_SAVE: marNext = SAVE_ADDR;
      default:       marNext = pcQ;
    endcase
  end

  always_comb begin
    case (strb.mbrSel)
      MBR_FROM_ACC: mbrNext = accQ;
      MBR_FROM_PC:  mbrNext = {{OP_W{1'b0}}, pcQ};
      default:      mbrNext = memRdData;
    endcase
  end

  always_comb begin
    case (strb.accOp)
      ACC_ADD: aluResult = accQ + mbrQ;
      ACC_SUB: aluResult = accQ - mbrQ;
      default: aluResult = mbrQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ  <= RESET_PC;
      marQ <= '0;
      mbrQ <= '0;
      cirQ <= '0;
      accQ <= '0;
    end else begin
      if (strb.marLoad) marQ <= marNext;
      if (strb.mbrLoad) mbrQ <= mbrNext;
      if (strb.cirLoad) cirQ <= mbrQ;
      if (strb.accLoad) accQ <= aluResult;
      if (strb.pcLoadVec)       pcQ <= VECTOR_ADDR;
      else if (strb.pcLoadMbr)  pcQ <= mbrQ[ADDR_W-1:0];
      else if (strb.pcLoadAddr) pcQ <= addrField;
      else if (strb.pcInc)      pcQ <= pcQ + 1'b1;
    end
  end

  assign memAddr   = marQ;
  assign memWrData = mbrQ;
  assign opcode    = cirQ[DATA_W-1 -: OP_W];
  assign accZero   = (accQ == '0);
  assign accOut    = accQ;
  assign pcOut     = pcQ;

endmodule

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [OP_W-1:0] opcode,
  input  logic            accZero,
  input  logic            irqReq,
  output ctrlStrobes_t    strb,
  output seqState_e       seqState,
  output logic            halted,
  output logic            inService
);

  seqState_e stateQ, stateNext;
  logic      maskQ;
  logic      maskSet, maskClr;

  always_comb begin
    strb      = '0;
    strb.marSel = MAR_FROM_PC;
    strb.mbrSel = MBR_FROM_MEM;
    strb.accOp  = ACC_PASS;
    maskSet   = 1'b0;
    maskClr   = 1'b0;
    stateNext = stateQ;
    case (stateQ)
      ST_FETCH_ADDR: begin
        strb.marLoad = 1'b1;
        strb.marSel  = MAR_FROM_PC;
        stateNext    = ST_FETCH_READ;
      end
      ST_FETCH_READ: begin
        strb.pcInc = 1'b1;
        stateNext  = ST_FETCH_MBR;
      end
      ST_FETCH_MBR: begin
        strb.mbrLoad = 1'b1;
        strb.mbrSel  = MBR_FROM_MEM;
        stateNext    = ST_DECODE;
      end
      ST_DECODE: begin
        strb.cirLoad = 1'b1;
        stateNext    = ST_EXEC_ADDR;
      end
      ST_EXEC_ADDR: begin
        case (opcode)
          OP_LOAD, OP_ADD, OP_SUB: begin
            strb.marLoad = 1'b1;
            strb.marSel  = MAR_FROM_CIR;
            stateNext    = ST_EXEC_MEM;
          end
          OP_STORE: begin
            strb.marLoad = 1'b1;
            strb.marSel  = MAR_FROM_CIR;
            strb.mbrLoad = 1'b1;
            strb.mbrSel  = MBR_FROM_ACC;
            stateNext    = ST_EXEC_MEM;
          end
          OP_RETI: begin
            strb.marLoad = 1'b1;
            strb.marSel  = MAR_FROM_SAVE;
            stateNext    = ST_EXEC_MEM;
          end
          OP_JMP: begin
            strb.pcLoadAddr = 1'b1;
            stateNext       = ST_INT_CHECK;
          end
          OP_JZ: begin
            strb.pcLoadAddr = accZero;
            stateNext       = ST_INT_CHECK;
          end
          default: stateNext = ST_HALTED;
        endcase
      end
      ST_EXEC_MEM: begin
        if (opcode == OP_STORE) begin
          strb.memWrite = 1'b1;
          stateNext     = ST_INT_CHECK;
        end else begin
          stateNext = ST_EXEC_MBR;
        end
      end
      ST_EXEC_MBR: begin
        strb.mbrLoad = 1'b1;
        strb.mbrSel  = MBR_FROM_MEM;
        stateNext    = ST_EXEC_DO;
      end
      ST_EXEC_DO: begin
        case (opcode)
          OP_ADD: begin
            strb.accLoad = 1'b1;
            strb.accOp   = ACC_ADD;
          end
          OP_SUB: begin
            strb.accLoad = 1'b1;
            strb.accOp   = ACC_SUB;
          end
          OP_RETI: begin
            strb.pcLoadMbr = 1'b1;
            maskClr        = 1'b1;
          end
          default: begin
            strb.accLoad = 1'b1;
            strb.accOp   = ACC_PASS;
          end
        endcase
        stateNext = ST_INT_CHECK;
      end
      ST_INT_CHECK: begin
        stateNext = (irqReq && !maskQ) ? ST_INT_SAVE : ST_FETCH_ADDR;
      end
      ST_INT_SAVE: begin
        strb.marLoad = 1'b1;
        strb.marSel  = MAR_FROM_SAVE;
        strb.mbrLoad = 1'b1;
        strb.mbrSel  = MBR_FROM_PC;
        stateNext    = ST_INT_WRITE;
      end
      ST_INT_WRITE: begin
        strb.memWrite  = 1'b1;
        strb.pcLoadVec = 1'b1;
        maskSet        = 1'b1;
        stateNext      = ST_FETCH_ADDR;
      end
      default: stateNext = ST_HALTED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_FETCH_ADDR;
      maskQ  <= 1'b0;
    end else begin
      stateQ <= stateNext;
      if (maskSet)      maskQ <= 1'b1;
      else if (maskClr) maskQ <= 1'b0;
    end
  end

  assign seqState  = stateQ;
  assign halted    = (stateQ == ST_HALTED);
  assign inService = maskQ;

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import cpu_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] RESET_PC    = 12'h010,
  parameter logic [ADDR_W-1:0] SAVE_ADDR   = 12'h000,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 12'h001
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   irqReq,
  input  logic [OP_W+ADDR_W-1:0] memRdData,
  output logic [ADDR_W-1:0]      memAddr,
  output logic                   memWrEn,
  output logic [OP_W+ADDR_W-1:0] memWrData,
  output logic [OP_W+ADDR_W-1:0] accOut,
  output logic [ADDR_W-1:0]      pcOut,
  output logic                   halted,
  output logic                   inService
);

  ctrlStrobes_t    strb;
  seqState_e       seqState;
  logic [OP_W-1:0] opcode;
  logic            accZero;

  cpu_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opcode    (opcode),
    .accZero   (accZero),
    .irqReq    (irqReq),
    .strb      (strb),
    .seqState  (seqState),
    .halted    (halted),
    .inService (inService)
  );

  cpu_datapath #(
    .ADDR_W      (ADDR_W),
    .RESET_PC    (RESET_PC),
    .SAVE_ADDR   (SAVE_ADDR),
    .VECTOR_ADDR (VECTOR_ADDR)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .opcode    (opcode),
    .accZero   (accZero),
    .accOut    (accOut),
    .pcOut     (pcOut)
  );

  assign memWrEn = strb.memWrite;

endmodule

// File: rtl/acc_cpu_checker.sv
module acc_cpu_checker
  import cpu_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] SAVE_ADDR   = 12'h000,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 12'h001
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_W-1:0]      memAddr,
  input logic                   memWrEn,
  input logic [OP_W+ADDR_W-1:0] memWrData,
  input logic [OP_W+ADDR_W-1:0] accOut,
  input logic [ADDR_W-1:0]      pcOut,
  input logic                   halted,
  input logic                   inService,
  input seqState_e              seqState
);

  // R2: the fetch address on memory is the pointer value
  assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_FETCH_READ) |-> (memAddr == pcOut));

  // R2: the pointer advances by one in the fetch
  assert_fetch_inc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == ST_FETCH_READ) |=> (pcOut == ADDR_W'($past(pcOut) + 1'b1)));

  // R7: a halted machine stays frozen
  assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && $stable(pcOut) && $stable(accOut)));

  // R7: no writes once halted
  assert_halt_nowrite_R7: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memWrEn);

  // R8: entry writes the save slot and lands on the vector
  assert_irq_entry_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inService) |-> (pcOut == VECTOR_ADDR && $past(memWrEn) && $past(memAddr) == SAVE_ADDR));

  // R8: the saved word is the return pointer
  assert_irq_save_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inService) |-> ($past(memWrData) == {{OP_W{1'b0}}, $past(pcOut)}));

  // R9: no second entry while masked
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (inService && seqState == ST_INT_CHECK) |=> (seqState != ST_INT_SAVE));

endmodule

bind acc_cpu acc_cpu_checker #(
  .ADDR_W      (ADDR_W),
  .SAVE_ADDR   (SAVE_ADDR),
  .VECTOR_ADDR (VECTOR_ADDR)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memAddr   (memAddr),
  .memWrEn   (memWrEn),
  .memWrData (memWrData),
  .accOut    (accOut),
  .pcOut     (pcOut),
  .halted    (halted),
  .inService (inService),
  .seqState  (seqState)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        irqReq = 1'b0;
  logic [15:0] memRdData;
  logic [11:0] memAddr;
  logic        memWrEn;
  logic [15:0] memWrData;
  logic [15:0] accOut;
  logic [11:0] pcOut;
  logic        halted;
  logic        inService;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  acc_cpu dut (
    .clk       (clk),
    .rstN      (rstN),
    .irqReq    (irqReq),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrEn   (memWrEn),
    .memWrData (memWrData),
    .accOut    (accOut),
    .pcOut     (pcOut),
    .halted    (halted),
    .inService (inService)
  );

  // memory model: one cycle read latency
  logic [15:0] mem [256];
  always @(posedge clk) begin
    if (memWrEn) mem[memAddr[7:0]] <= memWrData;
    memRdData <= mem[memAddr[7:0]];
  end

  typedef struct {
    logic [11:0] addr;
    logic [15:0] data;
    string       req;
  } wrItem_t;
  wrItem_t expQ[$];

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic expectWrite(logic [11:0] a, logic [15:0] d, string req);
    wrItem_t it;
    it.addr = a;
    it.data = d;
    it.req  = req;
    expQ.push_back(it);
  endtask

  // monitor: pop and compare every write
  always @(negedge clk) begin
    if (rstN && memWrEn) begin
      if (expQ.size() == 0) begin
        check("R7 unexpected write", {4'h0, memAddr, memWrData}, 32'hFFFF_FFFF);
      end else begin
        wrItem_t it;
        it = expQ.pop_front();
        check({it.req, " write"}, {4'h0, memAddr, memWrData}, {4'h0, it.addr, it.data});
      end
    end
  end

  function automatic logic [15:0] ins(logic [3:0] op, logic [11:0] a);
    return {op, a};
  endfunction

  task automatic clearMem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  endtask

  task automatic startReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic checkResetState();
    check("R1 pc", {20'h0, pcOut}, 32'h010);
    check("R1 acc", {16'h0, accOut}, 32'h0);
    check("R1 halted", {31'h0, halted}, 32'h0);
    check("R1 inService", {31'h0, inService}, 32'h0);
    check("R1 memWrEn", {31'h0, memWrEn}, 32'h0);
  endtask

  task automatic runToHalt(string req);
    int n = 0;
    while (!halted && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({req, " reached halt"}, {31'h0, halted}, 32'h1);
    check({req, " all writes seen"}, expQ.size(), 32'h0);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // ---------- program 1: load/add/sub/store, R1 R2 R3 R4 R5 R7 ----------
    startReset();
    clearMem();
    mem[8'h10] = ins(4'h1, 12'h080);
    mem[8'h11] = ins(4'h3, 12'h081);
    mem[8'h12] = ins(4'h2, 12'h090);
    mem[8'h13] = ins(4'h4, 12'h082);
    mem[8'h14] = ins(4'h2, 12'h091);
    mem[8'h15] = ins(4'h0, 12'h000);
    mem[8'h80] = 16'd5;
    mem[8'h81] = 16'd7;
    mem[8'h82] = 16'd20;
    expectWrite(12'h090, 16'd12, "R4 R5 add");
    expectWrite(12'h091, 16'hFFF8, "R4 R5 sub wrap");
    checkResetState();
    rstN = 1'b1;
    @(negedge clk);
    check("R2 fetch addr from pc", {20'h0, memAddr}, 32'h010);
    check("R2 pc before increment", {20'h0, pcOut}, 32'h010);
    @(negedge clk);
    check("R2 pc incremented", {20'h0, pcOut}, 32'h011);
    runToHalt("R3 R7 p1");
    check("R4 acc after sub", {16'h0, accOut}, 32'hFFF8);
    check("R7 pc after halt", {20'h0, pcOut}, 32'h016);
    repeat (10) @(negedge clk);
    check("R7 pc frozen", {20'h0, pcOut}, 32'h016);
    check("R7 still halted", {31'h0, halted}, 32'h1);

    // ---------- program 2: jumps and undefined opcode, R6 R7 ----------
    startReset();
    clearMem();
    mem[8'h10] = ins(4'h1, 12'h080);
    mem[8'h11] = ins(4'h6, 12'h014);
    mem[8'h12] = ins(4'h2, 12'h090);
    mem[8'h13] = ins(4'h0, 12'h000);
    mem[8'h14] = ins(4'h1, 12'h081);
    mem[8'h15] = ins(4'h6, 12'h012);
    mem[8'h16] = ins(4'h2, 12'h092);
    mem[8'h17] = ins(4'h5, 12'h019);
    mem[8'h18] = ins(4'h2, 12'h093);
    mem[8'h19] = ins(4'hF, 12'h000);
    mem[8'h80] = 16'd0;
    mem[8'h81] = 16'd3;
    expectWrite(12'h092, 16'd3, "R6 jz not taken");
    checkResetState();
    rstN = 1'b1;
    runToHalt("R6 R7 p2");
    check("R6 acc", {16'h0, accOut}, 32'h3);
    check("R7 undefined halts", {20'h0, pcOut}, 32'h01A);

    // ---------- program 3: interrupt entry, mask, return, R8 R9 R10 ----------
    startReset();
    clearMem();
    mem[8'h01] = ins(4'h1, 12'h083);
    mem[8'h02] = ins(4'h2, 12'h095);
    mem[8'h03] = ins(4'h7, 12'h000);
    mem[8'h10] = ins(4'h1, 12'h080);
    mem[8'h11] = ins(4'h3, 12'h081);
    mem[8'h12] = ins(4'h2, 12'h090);
    mem[8'h13] = ins(4'h0, 12'h000);
    mem[8'h80] = 16'd7;
    mem[8'h81] = 16'd1;
    mem[8'h83] = 16'd9;
    expectWrite(12'h000, 16'h0011, "R8 save pc");
    expectWrite(12'h095, 16'd9, "R9 isr store");
    expectWrite(12'h090, 16'd10, "R10 resumed");
    irqReq = 1'b1;
    rstN = 1'b1;
    begin
      int n = 0;
      do begin
        @(negedge clk);
        n++;
      end while (!(memWrEn && memAddr == 12'h095) && n < 3000);
    end
    check("R9 in service during isr", {31'h0, inService}, 32'h1);
    irqReq = 1'b0;
    runToHalt("R8 R10 p3");
    check("R10 unmasked", {31'h0, inService}, 32'h0);
    check("R10 acc", {16'h0, accOut}, 32'h000A);
    check("R10 pc", {20'h0, pcOut}, 32'h014);
    check("R8 save slot", {16'h0, mem[0]}, 32'h0011);

    finishRun();
  end

endmodule